// File: doc/BRIEF.md
# Victim/Aggressor Bit-Lane Stress Generator

This block exercises one cache line of memory with data that stresses each byte lane bit by bit. In every word, one bit position per byte (the victim) is driven from one pseudo-random stream. All the other bit positions (the aggressors) are driven from a second stream that is seeded separately. Each pass writes the whole line and then reads it back. The read data is compared against a regenerated copy of what was written. Any mismatch is recorded per byte lane.

The victim position moves on by one bit after every pass, so a single start covers every victim position without outside help. A controlling agent gives the line address, the number of passes and the two seeds. It pulses start and waits for the done pulse. It then reads the 8-bit lane failure mask. Memory requests are issued one word at a time and are held until granted. Read data returns in order on a separate valid strobe.

Top module: `lane_stress_gen`

## Requirements
- R1: While reset is asserted and after it, busy, done and mem_req are low and fail_mask is zero until the first start.
- R2: A start pulse while idle raises busy from the next cycle until completion. A start while busy has no effect on the run in progress, its data, its addresses or its pass count.
- R3: The run makes loop_cnt passes, and a loop_cnt of 0 counts as one pass. Each pass writes WORDS words to word addresses {line_addr, 0} through {line_addr, WORDS-1} in ascending order, then reads the same addresses in the same order.
- R4: Bit i of every written word comes from the victim stream when i mod 8 equals the current victim position, and from the aggressor stream otherwise. Bit i of a stream is bit (i mod 32) of its generator state.
- R5: The victim position is 0 in the first pass and goes up by one at each new pass, wrapping from 7 to 0.
- R6: Each generator is a 32-bit right-shifting Galois register with feedback mask 0xA3000000, and a zero seed is replaced by 1. The first word of a run uses the seeds themselves. The state steps once per accepted write, and the next pass continues from where the previous pass's writes ended.
- R7: For each read response, lane j (bits 8j+7..8j) fails if it differs from the data written to that word in that pass. fail_mask bit j is sticky over all passes of a run and is cleared by a new start.
- R8: done pulses high for exactly one cycle after the last read response of the last pass, and busy is low in that same cycle. fail_mask holds its value until the next start.
- R9: A request that is not granted stays asserted with the same address, direction and write data until mem_gnt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (taken only when idle) |
| line_addr | input | LINE_W | Cache-line index under test |
| loop_cnt | input | LOOP_W | Number of passes (0 counts as 1) |
| seed_vic | input | 32 | Victim stream seed |
| seed_agg | input | 32 | Aggressor stream seed |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | LINE_W+log2(WORDS) | Word address |
| mem_wdata | output | 8*LANES | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | Read data valid (in request order) |
| rd_data | input | 8*LANES | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| fail_mask | output | LANES | Sticky per-lane failure mask |

## Verification
The bench uses the defaults: eight lanes, eight words per line, a 26-bit line index and an 8-bit pass count. With these values a ten-pass run takes the victim position past 7 and back to 0. The 64-bit word also takes each 32-bit generator state twice, so the replication of stream bits across the upper lanes is checked. Runs with an intermittent grant and with faults injected on the read path show that held requests, sticky lane flags and zero-seed substitution all work at this size.

// File: rtl/lsg_pkg.sv
// Package: shared types and generator arithmetic for the lane stress generator.
// Assumes a 32-bit Galois register shifting right; a zero state is never used.
package lsg_pkg;

    localparam int          GEN_W    = 32;
    localparam logic [31:0] GEN_POLY = 32'hA300_0000;
    localparam logic [31:0] GEN_DFLT = 32'h0000_0001;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } lsg_state_t;

    // One Galois step: shift right, fold feedback mask when the bit shifted out is 1.
    function automatic logic [GEN_W-1:0] gen_next(input logic [GEN_W-1:0] s);
        return s[0] ? ((s >> 1) ^ GEN_POLY) : (s >> 1);
    endfunction

    // Replace a zero seed with the default so the register cannot lock up.
    function automatic logic [GEN_W-1:0] seed_fix(input logic [GEN_W-1:0] s);
        return (s == '0) ? GEN_DFLT : s;
    endfunction

endpackage

// File: rtl/lsg_gen.sv
// Module: one pattern stream with a bookmark.
// 'cur' is the live state. 'mark' holds the state from the start of the current
// pass's writes. A swap rewinds the live state for the read-back and parks the
// post-write state in mark, so the next pass continues from it.
// Assumes load, swap and step are never requested in a way that needs more than
// the fixed priority load > swap > step.
module lsg_gen
    import lsg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GEN_W-1:0] seed,
    input  logic             step,
    input  logic             swap,
    output logic [GEN_W-1:0] cur
);
    logic [GEN_W-1:0] live_q;
    logic [GEN_W-1:0] mark_q;

    // Update live and bookmark states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= GEN_DFLT;
            mark_q <= GEN_DFLT;
        end else if (load) begin
            live_q <= seed_fix(seed);
            mark_q <= seed_fix(seed);
        end else if (swap) begin
            live_q <= mark_q;
            mark_q <= gen_next(live_q);
        end else if (step) begin
            live_q <= gen_next(live_q);
        end
    end

    assign cur = live_q;

    // R6: the generator state never collapses to zero.
    p_gen_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q != '0 && mark_q != '0);

endmodule

// File: rtl/lsg_pattern.sv
// Module: builds one data word from the two stream states.
// Within every byte, the bit at the victim position takes the victim stream and
// all other bits take the aggressor stream. Bit i uses stream bit i mod 32.
// Purely combinational.
module lsg_pattern
    import lsg_pkg::*;
#(
    parameter int DATA_W = 64
)(
    input  logic [GEN_W-1:0]  vic_state,
    input  logic [GEN_W-1:0]  agg_state,
    input  logic [2:0]        victim,
    output logic [DATA_W-1:0] word
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        localparam logic [2:0] POS = 3'(i % 8);
        localparam int         SRC = i % GEN_W;
        // Pick the source stream for this bit.
        assign word[i] = (victim == POS) ? vic_state[SRC] : agg_state[SRC];
    end

endmodule

// File: rtl/lsg_lane_chk.sv
// Module: per-lane compare with sticky failure flags.
// A lane is flagged when any of its eight bits differs on a checked word.
// The flags are cleared by 'clear' and otherwise only ever set.
module lsg_lane_chk #(
    parameter int LANES = 8
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               check_en,
    input  logic [8*LANES-1:0] got,
    input  logic [8*LANES-1:0] exp,
    output logic [LANES-1:0]   fail
);
    logic [LANES-1:0] fail_q;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Accumulate the mismatch of lane j.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                fail_q[j] <= 1'b0;
            else if (check_en && (got[8*j +: 8] != exp[8*j +: 8]))
                fail_q[j] <= 1'b1;
        end
    end

    assign fail = fail_q;

    // R7: flags are sticky; without clear a set flag stays set.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (fail_q & $past(fail_q)) == $past(fail_q));

endmodule

// File: rtl/lane_stress_gen.sv
// Module: top of the bit-lane stress generator.
// Runs write/read/verify passes over one cache line. The victim bit position
// rotates every pass. The memory side accepts one request per granted cycle and
// returns read data in request order. Only one run is in flight at a time.
module lane_stress_gen
    import lsg_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int WORDS  = 8,
    parameter int LANES  = 8,
    parameter int LOOP_W = 8
)(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [LINE_W-1:0]              line_addr,
    input  logic [LOOP_W-1:0]              loop_cnt,
    input  logic [31:0]                    seed_vic,
    input  logic [31:0]                    seed_agg,
    output logic                           mem_req,
    output logic                           mem_we,
    output logic [LINE_W+$clog2(WORDS)-1:0] mem_addr,
    output logic [8*LANES-1:0]             mem_wdata,
    input  logic                           mem_gnt,
    input  logic                           rd_valid,
    input  logic [8*LANES-1:0]             rd_data,
    output logic                           busy,
    output logic                           done,
    output logic [LANES-1:0]               fail_mask
);
    localparam int          DATA_W   = 8 * LANES;
    localparam int          IDX_W    = $clog2(WORDS);
    localparam logic [IDX_W:0] CNT_LAST = (IDX_W+1)'(WORDS - 1);
    localparam logic [IDX_W:0] CNT_ALL  = (IDX_W+1)'(WORDS);

    lsg_state_t         st_q, st_d;
    logic [LINE_W-1:0]  line_q;
    logic [LOOP_W-1:0]  passes_q;
    logic [LOOP_W-1:0]  pass_q;
    logic [2:0]         vic_q;
    logic [IDX_W:0]     widx_q;
    logic [IDX_W:0]     ridx_q;
    logic [IDX_W:0]     rcnt_q;
    logic               done_q;

    logic               go;
    logic               wr_fire, wr_last, rd_fire, rsp, rsp_last, pass_last;
    logic [GEN_W-1:0]   vic_state, agg_state;
    logic [DATA_W-1:0]  pat_word;

    // Decode the events of this cycle.
    always_comb begin
        go        = start && (st_q == ST_IDLE);
        wr_fire   = (st_q == ST_WR) && mem_gnt;
        wr_last   = wr_fire && (widx_q == CNT_LAST);
        rd_fire   = (st_q == ST_RD) && (ridx_q != CNT_ALL) && mem_gnt;
        rsp       = (st_q == ST_RD) && rd_valid;
        rsp_last  = rsp && (rcnt_q == CNT_LAST);
        pass_last = (pass_q == passes_q - LOOP_W'(1));
    end

    // Next-state selection of the pass sequencer.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (go)       st_d = ST_WR;
            ST_WR:   if (wr_last)  st_d = ST_RD;
            ST_RD:   if (rsp_last) st_d = pass_last ? ST_IDLE : ST_WR;
            default:               st_d = ST_IDLE;
        endcase
    end

    // Sequencer state, run parameters and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            line_q   <= '0;
            passes_q <= LOOP_W'(1);
            pass_q   <= '0;
            vic_q    <= '0;
            widx_q   <= '0;
            ridx_q   <= '0;
            rcnt_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= rsp_last && pass_last;
            if (go) begin
                line_q   <= line_addr;
                passes_q <= (loop_cnt == '0) ? LOOP_W'(1) : loop_cnt;
                pass_q   <= '0;
                vic_q    <= '0;
                widx_q   <= '0;
            end
            if (wr_fire)
                widx_q <= wr_last ? '0 : widx_q + 1'b1;
            if (wr_last) begin
                ridx_q <= '0;
                rcnt_q <= '0;
            end
            if (rd_fire)
                ridx_q <= ridx_q + 1'b1;
            if (rsp)
                rcnt_q <= rcnt_q + 1'b1;
            if (rsp_last && !pass_last) begin
                pass_q <= pass_q + 1'b1;
                vic_q  <= vic_q + 1'b1;
            end
        end
    end

    lsg_gen u_vic (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .seed  (seed_vic),
        .step  ((wr_fire && !wr_last) || rsp),
        .swap  (wr_last),
        .cur   (vic_state)
    );

    lsg_gen u_agg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .seed  (seed_agg),
        .step  ((wr_fire && !wr_last) || rsp),
        .swap  (wr_last),
        .cur   (agg_state)
    );

    lsg_pattern #(.DATA_W(DATA_W)) u_pat (
        .vic_state (vic_state),
        .agg_state (agg_state),
        .victim    (vic_q),
        .word      (pat_word)
    );

    lsg_lane_chk #(.LANES(LANES)) u_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (go),
        .check_en (rsp),
        .got      (rd_data),
        .exp      (pat_word),
        .fail     (fail_mask)
    );

    // Drive the memory request from the sequencer state.
    always_comb begin
        mem_req   = (st_q == ST_WR) || ((st_q == ST_RD) && (ridx_q != CNT_ALL));
        mem_we    = (st_q == ST_WR);
        mem_addr  = {line_q, (st_q == ST_WR) ? widx_q[IDX_W-1:0] : ridx_q[IDX_W-1:0]};
        mem_wdata = pat_word;
    end

    assign busy = (st_q != ST_IDLE);
    assign done = done_q;

    // R9: an ungranted request holds address and direction.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R9: an ungranted write holds its data.
    p_wdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_gnt |=> $stable(mem_wdata));

    // R8: completion is a single pulse seen while idle.
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: an accepted start makes the block busy in the next cycle.
    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    // R5: the victim position advances by one at each new pass.
    p_victim_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RD && st_d == ST_WR) |=> vic_q == $past(vic_q) + 3'd1);

    // R7: a new run begins with a clear failure mask.
    p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> fail_mask == '0);

endmodule

// File: tb/sim_lane_stress_gen.sv
module sim_lane_stress_gen;
    localparam int LINE_W = 26;
    localparam int WORDS  = 8;
    localparam int LANES  = 8;
    localparam int LOOP_W = 8;
    localparam int DATA_W = 8 * LANES;
    localparam int ADDR_W = LINE_W + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LINE_W-1:0] line_addr = '0;
    logic [LOOP_W-1:0] loop_cnt = '0;
    logic [31:0]       seed_vic = '0;
    logic [31:0]       seed_agg = '0;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_gnt = 1'b1;
    logic              rd_valid = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              busy, done;
    logic [LANES-1:0]  fail_mask;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    lane_stress_gen #(.LINE_W(LINE_W), .WORDS(WORDS), .LANES(LANES), .LOOP_W(LOOP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .line_addr(line_addr),
        .loop_cnt(loop_cnt), .seed_vic(seed_vic), .seed_agg(seed_agg),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .done(done), .fail_mask(fail_mask)
    );

    always #2 clk = ~clk;

    // Expected-value helpers, built from the requirement text.
    function automatic logic [31:0] m_next(input logic [31:0] s);
        return s[0] ? ((s >> 1) ^ 32'hA300_0000) : (s >> 1);
    endfunction

    function automatic logic [DATA_W-1:0] m_pat(input logic [31:0] v, input logic [31:0] a,
                                                 input logic [2:0] vic);
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W; i++)
            w[i] = ((i % 8) == int'(vic)) ? v[i % 32] : a[i % 32];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model and fault injection.
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] fault_xor = '0;
    bit                fault_once = 1'b0;
    int                n_wr = 0;
    int                n_rd = 0;
    logic [1:0]        gmode = 2'd0;

    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr[2:0]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                rd_valid <= 1'b1;
                rd_data  <= mem[mem_addr[2:0]] ^ fault_xor;
                n_rd     <= n_rd + 1;
                if (fault_once) begin
                    fault_xor  <= '0;
                    fault_once <= 1'b0;
                end
            end
        end
    end

    // Grant generator, changed shortly after each edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        mem_gnt = (gmode == 2'd0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // Write monitor: compares each accepted write against the model streams.
    logic [31:0]       bv = '0, ba = '0;
    logic [2:0]        bvic = '0;
    int                bcnt = 0;
    int                mon_err = 0;
    logic [LINE_W-1:0] bline = '0;

    always @(negedge clk) begin
        if (rst_n && mem_req && mem_gnt && mem_we) begin
            if (mem_wdata !== m_pat(bv, ba, bvic) ||
                mem_addr !== {bline, 3'(bcnt % WORDS)}) begin
                mon_err++;
                if (mon_err < 4)
                    $display("FAIL R4/R6 write word %0d actual=%0h expected=%0h",
                             bcnt, mem_wdata, m_pat(bv, ba, bvic));
            end
            bv = m_next(bv);
            ba = m_next(ba);
            bcnt++;
            if (bcnt % WORDS == 0) bvic = bvic + 3'd1;
        end
    end

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // One full run: program, start, optionally poke start mid-run, then check.
    task automatic do_run(input string name, input logic [LINE_W-1:0] ln,
                          input logic [LOOP_W-1:0] lc, input logic [31:0] sv,
                          input logic [31:0] sa, input logic [1:0] gm,
                          input logic [DATA_W-1:0] fx, input bit once,
                          input bit restart_mid, input logic [LANES-1:0] exp_mask);
        int passes;
        int waitc;
        passes = (lc == 0) ? 1 : int'(lc);
        @(posedge clk); #1;
        gmode      = gm;
        fault_xor  = fx;
        fault_once = once;
        bv = (sv == 0) ? 32'h1 : sv;
        ba = (sa == 0) ? 32'h1 : sa;
        bvic = '0; bcnt = 0; mon_err = 0; bline = ln;
        n_wr = 0; n_rd = 0;
        line_addr = ln; loop_cnt = lc; seed_vic = sv; seed_agg = sa;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, {"R2 busy after start ", name}, 64'(busy), 64'd1);
        if (restart_mid) begin
            repeat (5) @(posedge clk);
            #1;
            line_addr = ~ln; loop_cnt = 8'd1; seed_vic = 32'h1234; seed_agg = 32'h9;
            start = 1'b1;
            @(posedge clk); #1;
            start = 1'b0;
        end
        waitc = 0;
        while (done !== 1'b1 && waitc < 20000) begin
            @(negedge clk);
            waitc++;
        end
        check(done == 1'b1, {"R8 done seen ", name}, 64'(done), 64'd1);
        check(busy == 1'b0, {"R8 busy low with done ", name}, 64'(busy), 64'd0);
        check(mon_err == 0, {"R4 R5 R6 write data and address ", name}, 64'(mon_err), 64'd0);
        check(n_wr == passes * WORDS, {"R3 write count ", name}, 64'(n_wr), 64'(passes * WORDS));
        check(n_rd == passes * WORDS, {"R3 read count ", name}, 64'(n_rd), 64'(passes * WORDS));
        check(fail_mask == exp_mask, {"R7 fail mask ", name}, 64'(fail_mask), 64'(exp_mask));
        @(negedge clk);
        check(done == 1'b0, {"R8 done single pulse ", name}, 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        check(fail_mask == exp_mask && !mem_req, {"R8 mask held while idle ", name},
              64'(fail_mask), 64'(exp_mask));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_req && fail_mask == '0, "R1 reset state",
              {busy, done, mem_req, 5'd0, 56'(fail_mask)}, 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && !mem_req && fail_mask == '0, "R1 idle after reset",
              {busy, done, mem_req, 5'd0, 56'(fail_mask)}, 64'd0);
    endtask

    task automatic t_basic;
        do_run("basic", 26'h123_4567, 8'd3, 32'hDEAD_BEEF, 32'h0BAD_F00D, 2'd0, '0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_wrap_stall;
        // R5 wrap past 7 and R9 ungranted requests held.
        do_run("wrap_stall", 26'h000_0040, 8'd10, 32'h8000_0001, 32'h5A5A_A5A5, 2'd1, '0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_zero_seed;
        // R6 zero seeds replaced by 1; loop count 0 runs one pass (R3).
        do_run("zero_seed", 26'h3FF_FFFF, 8'd0, 32'h0, 32'h0, 2'd0, '0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_fault_lane;
        // R7 a stuck flip in lane 3 on every read.
        do_run("fault_lane3", 26'h000_0100, 8'd2, 32'h1357_9BDF, 32'h2468_ACE0, 2'd1,
               64'h0000_0000_0800_0000, 1'b0, 1'b0, 8'h08);
    endtask

    task automatic t_fault_once;
        // R7 a one-off flip in lanes 0 and 6 during pass 0 stays flagged.
        do_run("fault_once", 26'h000_0200, 8'd4, 32'hCAFE_0001, 32'h0000_FFFF, 2'd0,
               64'h0010_0000_0000_0001, 1'b1, 1'b0, 8'h41);
    endtask

    task automatic t_restart_ignored;
        // R2 start while busy must not disturb the run; mask cleared by new start (R7).
        do_run("restart_ignored", 26'h000_0300, 8'd3, 32'h0F0F_0F0F, 32'h7777_1111, 2'd0, '0, 1'b0, 1'b1, 8'h00);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_wrap_stall();
        t_zero_seed();
        t_fault_lane();
        t_fault_once();
        t_restart_ignored();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule